// File: doc/BRIEF.md
# Self-Timed Word Programming Sequencer

This block runs the programming phase of a small word-organized nonvolatile array once a serial command front end has finished collecting a command. The front end hands over a one-cycle start strobe together with an operation code, an address and a data word. The sequencer then holds the array busy for a fixed, per-operation number of system clock ticks. When that window ends it applies the change to the array: erase one word, write one word, erase the whole array, or write the whole array. A write of the whole array first clears the array and then fills it, and each of those two phases takes half of its window.

A command starts only when three conditions hold: chip select is high, the erase/write enable latch held by the front end is set, and the program-enable pin is high. Once a cycle has begun it runs to completion whatever chip select does. A start strobe that arrives during a cycle is dropped and sets a sticky error flag. An organization input picks 16-bit words or 8-bit bytes. In byte mode the address carries one extra low bit that selects the byte lane inside a stored word. The array is an internal register file. It has a combinational read port and also exposes its write port at the boundary.

Top module: `nvm_prog_seq`

## Requirements
- R1: An erase command (op code 00) sets every bit of the addressed unit to 1 when its window ends: the whole 16-bit word in word mode, or only the selected byte in byte mode.
- R2: A write command (op code 01) stores the supplied data in the addressed unit when its window ends. Nothing else in the array changes.
- R3: An erase-all command (op code 10) sets every word of the array to all ones when its window ends. It produces exactly one bulk write on the array port.
- R4: A write-all command (op code 11) clears the whole array to all ones after T_WALL/2 ticks. It then fills every word with the data at the end of T_WALL ticks. It produces exactly two bulk writes.
- R5: After an accepted start, `ready` is 0 for exactly T_WORD cycles (erase, write), T_CLEAR cycles (erase-all) or T_WALL cycles (write-all), and then returns to 1.
- R6: A start with `wr_en` low is ignored: `ready` stays 1 and the array is unchanged.
- R7: A start with `prog_en` low is ignored: `ready` stays 1 and the array is unchanged.
- R8: A start strobe while `ready` is 0 does not change the running cycle or the array. It sets `err`, which stays 1 until reset.
- R9: With `org_x16` low (byte mode), address bit 0 selects the byte lane (0 = low byte, bits 7:0) and the upper bits select the word. Only data bits 7:0 are used. A byte-mode write-all writes that byte into both lanes of every word. A byte-mode read returns the selected byte zero-extended.
- R10: After reset `ready` is 1, `err` is 0, and every array word reads 16'hFFFF.
- R11: A start with `sel` low is ignored. Dropping `sel` during a cycle neither shortens nor cancels it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle command strobe from the front end |
| op | input | 2 | Operation code: 00 erase, 01 write, 10 erase-all, 11 write-all |
| org_x16 | input | 1 | 1 = 16-bit words, 0 = 8-bit bytes for the command |
| addr | input | ADDR_W+1 | Command address (word index in word mode, byte address in byte mode) |
| din | input | 16 | Command data word |
| sel | input | 1 | Chip select level |
| wr_en | input | 1 | Erase/write enable latch state |
| prog_en | input | 1 | Program-enable pin, high permits programming |
| rd_addr | input | ADDR_W+1 | Read address, same convention as addr |
| rd_x16 | input | 1 | Organization used for the read port |
| rd_data | output | 16 | Read data |
| ready | output | 1 | 1 when idle, 0 while a cycle is running |
| err | output | 1 | Sticky flag for a start received while busy |
| arr_we | output | 1 | Array write strobe |
| arr_all | output | 1 | Write applies to every word |
| arr_idx | output | ADDR_W | Word index of a single-word write |
| arr_wdata | output | 16 | Array write data |
| arr_bmask | output | 2 | Byte-lane enables of the array write |

## Verification
The hardest state to reach from the ports is the midpoint of a write-all. There the array has been cleared but not yet filled. The stimulus first stores a distinctive pattern, then starts a write-all and reads that word exactly T_WALL/2 cycles later, expecting all ones before the fill appears. A second hard case is a start strobe that lands inside a running cycle. The bench injects one two cycles into a word write and then confirms three things: the window length is unchanged, the second target word is untouched, and the error flag stays set.

// File: rtl/nvm_prog_pkg.sv
package nvm_prog_pkg;

    localparam int BYTE_W = 8;
    localparam int LANES  = 2;
    localparam int WORD_W = BYTE_W * LANES;

    typedef enum logic [1:0] {
        OP_ERASE     = 2'b00,
        OP_WRITE     = 2'b01,
        OP_CLEAR_ALL = 2'b10,
        OP_FILL_ALL  = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_WORD,
        PH_CLEAR,
        PH_FILL
    } phase_e;

    typedef struct packed {
        logic              we;
        logic              all;
        logic [LANES-1:0]  bmask;
        logic [WORD_W-1:0] wdata;
    } wport_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // byte mode replicates the low byte into both lanes
    function automatic logic [WORD_W-1:0] lane_spread(input logic x16,
                                                      input logic [WORD_W-1:0] d);
        return x16 ? d : {d[BYTE_W-1:0], d[BYTE_W-1:0]};
    endfunction

    function automatic logic [LANES-1:0] lane_mask(input logic x16, input logic hi);
        if (x16) return '1;
        return hi ? 2'b10 : 2'b01;
    endfunction

endpackage

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/nvm_prog_ctrl.sv
module nvm_prog_ctrl
    import nvm_prog_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int CNT_W   = 8,
    parameter int T_WORD  = 40,
    parameter int T_CLEAR = 120,
    parameter int T_WALL  = 240
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic              x16,
    input  logic [ADDR_W:0]   addr,
    input  logic [WORD_W-1:0] din,
    input  logic              sel,
    input  logic              wr_en,
    input  logic              prog_en,
    input  logic              tmr_zero,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output logic              ready,
    output logic              err,
    output wport_t            wp,
    output logic [ADDR_W-1:0] w_idx
);
    localparam int T_HALF_A = T_WALL / 2;
    localparam int T_HALF_B = T_WALL - T_HALF_A;

    phase_e            ph_q, ph_d;
    op_e               op_q;
    logic              x16_q, hi_q, err_q;
    logic [ADDR_W-1:0] idx_q;
    logic [WORD_W-1:0] dat_q;
    logic              go;

    function automatic logic [CNT_W-1:0] first_window(input op_e o);
        case (o)
            OP_CLEAR_ALL: return CNT_W'(T_CLEAR - 1);
            OP_FILL_ALL:  return CNT_W'(T_HALF_A - 1);
            default:      return CNT_W'(T_WORD - 1);
        endcase
    endfunction

    assign go = start && sel && wr_en && prog_en && (ph_q == PH_IDLE);

    always_comb begin
        ph_d     = ph_q;
        tmr_load = 1'b0;
        tmr_val  = first_window(op_e'(op));
        wp       = '0;
        case (ph_q)
            PH_IDLE: begin
                if (go) begin
                    tmr_load = 1'b1;
                    ph_d = (op_e'(op) == OP_ERASE || op_e'(op) == OP_WRITE)
                           ? PH_WORD : PH_CLEAR;
                end
            end
            PH_WORD: begin
                if (tmr_zero) begin
                    wp.we    = 1'b1;
                    wp.bmask = lane_mask(x16_q, hi_q);
                    wp.wdata = (op_q == OP_ERASE) ? '1 : lane_spread(x16_q, dat_q);
                    ph_d     = PH_IDLE;
                end
            end
            PH_CLEAR: begin
                if (tmr_zero) begin
                    wp.we    = 1'b1;
                    wp.all   = 1'b1;
                    wp.bmask = '1;
                    wp.wdata = '1;
                    if (op_q == OP_FILL_ALL) begin
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(T_HALF_B - 1);
                        ph_d     = PH_FILL;
                    end else begin
                        ph_d = PH_IDLE;
                    end
                end
            end
            PH_FILL: begin
                if (tmr_zero) begin
                    wp.we    = 1'b1;
                    wp.all   = 1'b1;
                    wp.bmask = '1;
                    wp.wdata = lane_spread(x16_q, dat_q);
                    ph_d     = PH_IDLE;
                end
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            op_q  <= OP_ERASE;
            x16_q <= 1'b1;
            hi_q  <= 1'b0;
            idx_q <= '0;
            dat_q <= '0;
            err_q <= 1'b0;
        end else begin
            ph_q <= ph_d;
            if (go) begin
                op_q  <= op_e'(op);
                x16_q <= x16;
                hi_q  <= x16 ? 1'b0 : addr[0];
                idx_q <= x16 ? addr[ADDR_W-1:0] : addr[ADDR_W:1];
                dat_q <= din;
            end
            if (start && ph_q != PH_IDLE)
                err_q <= 1'b1;
        end
    end

    assign ready = (ph_q == PH_IDLE);
    assign err   = err_q;
    assign w_idx = idx_q;
endmodule

// File: rtl/nvm_prog_array.sv
module nvm_prog_array
    import nvm_prog_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  wport_t            wp,
    input  logic [ADDR_W-1:0] w_idx,
    input  logic [ADDR_W-1:0] rd_idx,
    output logic [WORD_W-1:0] rd_word
);
    localparam int DEPTH = 2 ** ADDR_W;

    logic [WORD_W-1:0] rows [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        logic [LANES-1:0][BYTE_W-1:0] cell_q;
        logic                         hit;

        assign hit = wp.we && (wp.all || w_idx == ADDR_W'(w));

        always_ff @(posedge clk) begin
            for (int b = 0; b < LANES; b++) begin
                if (rst)
                    cell_q[b] <= '1;
                else if (hit && wp.bmask[b])
                    cell_q[b] <= wp.wdata[b*BYTE_W +: BYTE_W];
            end
        end

        assign rows[w] = cell_q;
    end

    assign rd_word = rows[rd_idx];
endmodule

// File: rtl/nvm_prog_seq.sv
module nvm_prog_seq
    import nvm_prog_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int T_WORD  = 40,
    parameter int T_CLEAR = 120,
    parameter int T_WALL  = 240
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic              org_x16,
    input  logic [ADDR_W:0]   addr,
    input  logic [15:0]       din,
    input  logic              sel,
    input  logic              wr_en,
    input  logic              prog_en,
    input  logic [ADDR_W:0]   rd_addr,
    input  logic              rd_x16,
    output logic [15:0]       rd_data,
    output logic              ready,
    output logic              err,
    output logic              arr_we,
    output logic              arr_all,
    output logic [ADDR_W-1:0] arr_idx,
    output logic [15:0]       arr_wdata,
    output logic [1:0]        arr_bmask
);
    localparam int CNT_W = $clog2(max3(T_WORD, T_CLEAR, T_WALL) + 1);

    wport_t            wp;
    logic [ADDR_W-1:0] w_idx, rd_idx;
    logic [WORD_W-1:0] rd_word;
    logic              tmr_load, tmr_zero;
    logic [CNT_W-1:0]  tmr_val;

    nvm_prog_ctrl #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W),
        .T_WORD(T_WORD), .T_CLEAR(T_CLEAR), .T_WALL(T_WALL)
    ) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .op(op), .x16(org_x16),
        .addr(addr), .din(din), .sel(sel), .wr_en(wr_en), .prog_en(prog_en),
        .tmr_zero(tmr_zero), .tmr_load(tmr_load), .tmr_val(tmr_val),
        .ready(ready), .err(err), .wp(wp), .w_idx(w_idx)
    );

    nvm_prog_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    assign rd_idx = rd_x16 ? rd_addr[ADDR_W-1:0] : rd_addr[ADDR_W:1];

    nvm_prog_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk(clk), .rst(rst), .wp(wp), .w_idx(w_idx),
        .rd_idx(rd_idx), .rd_word(rd_word)
    );

    assign rd_data = rd_x16 ? rd_word
                   : {8'h00, rd_addr[0] ? rd_word[15:8] : rd_word[7:0]};

    assign arr_we    = wp.we;
    assign arr_all   = wp.all;
    assign arr_idx   = w_idx;
    assign arr_wdata = wp.wdata;
    assign arr_bmask = wp.bmask;
endmodule

// File: rtl/nvm_prog_seq_chk.sv
module nvm_prog_seq_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic sel,
    input logic wr_en,
    input logic prog_en,
    input logic ready,
    input logic err,
    input logic arr_we
);
    // R6
    gate_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && start && !wr_en) |=> ready);

    // R7
    gate_pin_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && start && !prog_en) |=> ready);

    // R11
    gate_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && start && !sel) |=> ready);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R8
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> $past(start && !ready));

    // R2
    we_busy_chk: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> !ready);

    // R5
    ready_commit_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(arr_we));
endmodule

bind nvm_prog_seq nvm_prog_seq_chk u_chk (
    .clk(clk), .rst(rst), .start(start), .sel(sel), .wr_en(wr_en),
    .prog_en(prog_en), .ready(ready), .err(err), .arr_we(arr_we)
);

// File: tb/sim_nvm_prog_seq.sv
`timescale 1ns/1ps
module sim_nvm_prog_seq;
    import nvm_prog_pkg::*;

    localparam int AW      = 3;
    localparam int T_WORD  = 6;
    localparam int T_CLEAR = 10;
    localparam int T_WALL  = 14;
    localparam int HALF    = T_WALL / 2;

    logic clk = 1'b0, rst = 1'b1;
    logic start = 1'b0, org_x16 = 1'b1, sel = 1'b1, wr_en = 1'b0, prog_en = 1'b1;
    logic [1:0] op = 2'b00;
    logic [AW:0] addr = '0, rd_addr = '0;
    logic [15:0] din = '0;
    logic rd_x16 = 1'b1;
    logic [15:0] rd_data, arr_wdata;
    logic ready, err, arr_we, arr_all;
    logic [AW-1:0] arr_idx;
    logic [1:0] arr_bmask;

    int n_run = 0, n_fail = 0, n_bulk = 0;

    typedef struct {
        string      tag;
        logic [AW:0] a;
        logic       x16;
        logic [15:0] exp;
    } rd_item_t;
    rd_item_t q[$];

    always #4 clk = ~clk;

    nvm_prog_seq #(.ADDR_W(AW), .T_WORD(T_WORD), .T_CLEAR(T_CLEAR), .T_WALL(T_WALL)) u0 (
        .clk(clk), .rst(rst), .start(start), .op(op), .org_x16(org_x16),
        .addr(addr), .din(din), .sel(sel), .wr_en(wr_en), .prog_en(prog_en),
        .rd_addr(rd_addr), .rd_x16(rd_x16), .rd_data(rd_data), .ready(ready),
        .err(err), .arr_we(arr_we), .arr_all(arr_all), .arr_idx(arr_idx),
        .arr_wdata(arr_wdata), .arr_bmask(arr_bmask)
    );

    always @(negedge clk) if (arr_we && arr_all) n_bulk++;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic expect_rd(input string tag, input logic [AW:0] a,
                             input logic x16, input logic [15:0] exp);
        rd_item_t it;
        it.tag = tag; it.a = a; it.x16 = x16; it.exp = exp;
        q.push_back(it);
    endtask

    // monitor: pops expected read items and compares them
    initial begin
        rd_item_t it;
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                it = q.pop_front();
                rd_addr = it.a;
                rd_x16  = it.x16;
                #1;
                chk(it.tag, rd_data, it.exp);
            end
        end
    end

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic issue(input op_e o, input logic x16, input logic [AW:0] a,
                         input logic [15:0] d);
        op = o; org_x16 = x16; addr = a; din = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (!ready) begin n++; @(negedge clk); end
    endtask

    task automatic word_all(input string tag, input logic [15:0] exp);
        for (int w = 0; w < 2**AW; w++) expect_rd(tag, (AW+1)'(w), 1'b1, exp);
    endtask

    initial begin
        int n, b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        chk("R10 ready", {15'd0, ready}, 16'd1);
        chk("R10 err", {15'd0, err}, 16'd0);
        word_all("R10 array", 16'hFFFF);
        drain();

        // R6 latch clear: ignored
        issue(OP_WRITE, 1'b1, 4'd3, 16'h1234);
        chk("R6 ready", {15'd0, ready}, 16'd1);
        expect_rd("R6 word3", 4'd3, 1'b1, 16'hFFFF);
        drain();

        // R7 program pin low: ignored
        wr_en = 1'b1; prog_en = 1'b0;
        issue(OP_WRITE, 1'b1, 4'd3, 16'h1234);
        chk("R7 ready", {15'd0, ready}, 16'd1);
        expect_rd("R7 word3", 4'd3, 1'b1, 16'hFFFF);
        drain();
        prog_en = 1'b1;

        // R11 select low at start: ignored
        sel = 1'b0;
        issue(OP_WRITE, 1'b1, 4'd3, 16'h1234);
        chk("R11 ready", {15'd0, ready}, 16'd1);
        sel = 1'b1;
        expect_rd("R11 word3", 4'd3, 1'b1, 16'hFFFF);
        drain();

        // R2 / R5 word write
        issue(OP_WRITE, 1'b1, 4'd3, 16'hA5C3);
        busy_len(n);
        chk("R5 write window", 16'(n), 16'(T_WORD));
        expect_rd("R2 word3", 4'd3, 1'b1, 16'hA5C3);
        expect_rd("R2 word2 untouched", 4'd2, 1'b1, 16'hFFFF);
        drain();

        // R1 word erase
        issue(OP_ERASE, 1'b1, 4'd3, 16'h0000);
        busy_len(n);
        chk("R5 erase window", 16'(n), 16'(T_WORD));
        expect_rd("R1 word3", 4'd3, 1'b1, 16'hFFFF);
        drain();

        // R8 start while busy
        issue(OP_WRITE, 1'b1, 4'd5, 16'h1111);
        n = 0;
        while (!ready) begin
            n++;
            if (n == 2) begin op = OP_WRITE; addr = 4'd6; din = 16'h2222; start = 1'b1; end
            if (n == 3) start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        chk("R8 window kept", 16'(n), 16'(T_WORD));
        chk("R8 err set", {15'd0, err}, 16'd1);
        expect_rd("R8 word5", 4'd5, 1'b1, 16'h1111);
        expect_rd("R8 word6 untouched", 4'd6, 1'b1, 16'hFFFF);
        drain();
        chk("R8 err sticky", {15'd0, err}, 16'd1);

        // R11 select dropped mid-cycle
        issue(OP_WRITE, 1'b1, 4'd1, 16'h0BEE);
        n = 0;
        while (!ready) begin
            n++;
            if (n == 1) sel = 1'b0;
            @(negedge clk);
        end
        sel = 1'b1;
        chk("R11 window kept", 16'(n), 16'(T_WORD));
        expect_rd("R11 word1", 4'd1, 1'b1, 16'h0BEE);
        drain();

        // R3 erase-all
        b0 = n_bulk;
        issue(OP_CLEAR_ALL, 1'b1, 4'd0, 16'h0000);
        busy_len(n);
        chk("R5 erase-all window", 16'(n), 16'(T_CLEAR));
        chk("R3 bulk count", 16'(n_bulk - b0), 16'd1);
        word_all("R3 array", 16'hFFFF);
        drain();

        // R9 byte mode
        issue(OP_WRITE, 1'b0, 4'd5, 16'hAB7E);
        busy_len(n);
        chk("R9 byte window", 16'(n), 16'(T_WORD));
        expect_rd("R9 high lane", 4'd2, 1'b1, 16'h7EFF);
        drain();
        issue(OP_WRITE, 1'b0, 4'd4, 16'h0012);
        busy_len(n);
        expect_rd("R9 low lane", 4'd2, 1'b1, 16'h7E12);
        expect_rd("R9 byte read", 4'd5, 1'b0, 16'h007E);
        expect_rd("R9 word3 untouched", 4'd3, 1'b1, 16'hFFFF);
        drain();
        issue(OP_ERASE, 1'b0, 4'd4, 16'h0000);
        busy_len(n);
        expect_rd("R1 byte erase", 4'd2, 1'b1, 16'h7EFF);
        drain();

        // R4 write-all with visible clear midpoint
        b0 = n_bulk;
        issue(OP_FILL_ALL, 1'b1, 4'd0, 16'h5A3C);
        repeat (HALF) @(negedge clk);
        rd_addr = 4'd2; rd_x16 = 1'b1;
        #1;
        chk("R4 midpoint cleared", rd_data, 16'hFFFF);
        chk("R4 midpoint busy", {15'd0, ready}, 16'd0);
        n = HALF;
        while (!ready) begin n++; @(negedge clk); end
        chk("R5 write-all window", 16'(n), 16'(T_WALL));
        chk("R4 bulk count", 16'(n_bulk - b0), 16'd2);
        word_all("R4 array", 16'h5A3C);
        drain();

        // R9 byte-mode write-all
        issue(OP_FILL_ALL, 1'b0, 4'd0, 16'h3396);
        busy_len(n);
        word_all("R9 fill lanes", 16'h9696);
        drain();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule